// File: doc/BRIEF.md
# Dual-Register DDS Phase Generator

This block is the phase-generation core of a direct digital synthesiser. It stores two 32-bit frequency tuning words and four 12-bit phase-offset words. On every clock it adds the chosen tuning word into a 32-bit phase accumulator. It then adds the chosen offset to the top 12 bits of the accumulator, and that 12-bit sum is the phase word presented to a sine lookup. The output frequency is the clock rate times the tuning word divided by 2^32. One offset step is 2π/4096 of phase.

The active frequency and phase words are picked either by external select pins or by select-bit inputs, depending on a source mode bit. Selections and newly written words reach the output through a pipeline of fixed length. An optional resynchronisation mode lengthens that pipeline by two cycles. Other controls:
- An accumulator reset zeroes the phase but keeps the stored words.
- Sleep freezes the accumulator.
- Clear returns selection to the pins and turns resynchronisation off.

Stored words are loaded through a plain parallel write port.

Top module: `dds_phase_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the accumulator, all stored words, both mode bits and the pipeline are cleared, so `phase_o` reads 0.
- R2: The accumulator advances by the selected tuning word modulo 2^32 each cycle. `phase_o` equals (accumulator bits 31..20 + selected offset) modulo 4096.
- R3: A write with `wr_kind_i`=0 loads tuning word `wr_addr_i` (0 or 1) with all 32 data bits. A write with `wr_kind_i`=1 loads offset `wr_addr_i` (0..3) with data bits 11..0. A frequency select value of 0 or 1 picks tuning word 0 or 1, and a phase select value of 0..3 picks offset 0..3.
- R4: With resynchronisation off, a select input sampled at edge N first shows on `phase_o` after edge N+5.
- R5: With resynchronisation on, a select input sampled at edge N first shows on `phase_o` after edge N+7.
- R6: A write at edge N to the selected word first shows on `phase_o` after edge N+5, or after edge N+7 with resynchronisation on.
- R7: While `acc_reset_i` is held, the accumulator is zero and `phase_o` equals the selected offset. The stored words are not changed.
- R8: If `acc_reset_i` is sampled low at edge N, then after edge N+5+j `phase_o` reflects an accumulator value of F·(j+1), where F is the selected word. This holds in both resynchronisation modes.
- R9: `clr_i` forces both mode bits to 0 and takes priority over a simultaneous mode write. Selection then comes from the pins with the six-cycle latency.
- R10: With source mode 1, `bit_fsel_i`/`bit_psel_i` pick the words and the pins are ignored. With source mode 0, the pins pick the words and the bits are ignored.
- R11: `sleep_i` sampled high at edge N freezes the accumulator from edge N+2 on. `phase_o` still steps after edge N+4 and then holds its value. After release, stepping resumes with the same five-edge delay.
- R12: `mode_wr_i` at a clock edge loads the resynchronisation bit from `mode_sync_i` and the source bit from `mode_src_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Store a word this cycle |
| wr_kind_i | input | 1 | 0 = tuning word, 1 = phase offset |
| wr_addr_i | input | 2 | Index of the word to store |
| wr_data_i | input | 32 | Word to store (offsets use bits 11..0) |
| mode_wr_i | input | 1 | Load the mode bits |
| mode_sync_i | input | 1 | Resynchronisation bit value to load |
| mode_src_i | input | 1 | Source bit value to load (1 = select bits) |
| clr_i | input | 1 | Force both mode bits to 0 |
| acc_reset_i | input | 1 | Hold the accumulator at zero |
| sleep_i | input | 1 | Freeze the accumulator |
| pin_fsel_i | input | 1 | Frequency select pin |
| pin_psel_i | input | 2 | Phase select pins |
| bit_fsel_i | input | 1 | Frequency select bit |
| bit_psel_i | input | 2 | Phase select bits |
| phase_o | output | 12 | Phase word for the sine lookup |

## Verification
Some properties are checked on every cycle:
- The accumulator steps by exactly the word handed to it, or stays still during sleep, or is zero after an accumulator reset.
- Clear empties both mode bits.
- Stored words change only on a write.

The exact pipeline latencies cannot be seen by a local property, so the bench's scenarios have to show them:
- six or eight cycles for selects and writes;
- the five-edge delay of reset release and sleep;
- the interplay of clear with a simultaneous mode write;
- the choice between pins and bits.

The bench's scenarios also cover the wrap of the accumulator and of the offset sum.

// File: rtl/dds_pkg.sv
// Package: shared defaults and encodings for the DDS phase core.
// Assumes: consumers take widths as parameters defaulting to these values.
package dds_pkg;
    localparam int ACC_W_DEF       = 32;  // phase accumulator width
    localparam int OUT_W_DEF       = 12;  // offset / output phase width
    localparam int N_FREQ_DEF      = 2;   // number of tuning words
    localparam int N_PHASE_DEF     = 4;   // number of phase offsets
    localparam int SYNC_STAGES_DEF = 2;   // extra stages when resync is on

    typedef enum logic {
        WR_FREQ  = 1'b0,
        WR_PHASE = 1'b1
    } wr_kind_e;
endpackage

// File: rtl/dds_ctrl.sv
// Module: dds_ctrl
// Holds the mode bits (resync, select source), chooses the select source,
// samples the selects, and delays the accumulator reset and sleep so they
// line up with the lookup stage.
// Assumes: CTRL_DLY >= 2; clear has priority over a mode write.
module dds_ctrl #(
    parameter int FSEL_W   = 1,
    parameter int PSEL_W   = 2,
    parameter int CTRL_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              mode_wr_i,
    input  logic              mode_sync_i,
    input  logic              mode_src_i,
    input  logic [FSEL_W-1:0] pin_fsel_i,
    input  logic [PSEL_W-1:0] pin_psel_i,
    input  logic [FSEL_W-1:0] bit_fsel_i,
    input  logic [PSEL_W-1:0] bit_psel_i,
    input  logic              acc_reset_i,
    input  logic              sleep_i,
    output logic              mode_sync_o,
    output logic              mode_src_o,
    output logic [FSEL_W-1:0] fsel_o,
    output logic [PSEL_W-1:0] psel_o,
    output logic              acc_clr_o,
    output logic              acc_hold_o
);
    logic              sync_q;
    logic              src_q;
    logic [FSEL_W-1:0] fsel_mux;
    logic [PSEL_W-1:0] psel_mux;
    logic [FSEL_W-1:0] fsel_q;
    logic [PSEL_W-1:0] psel_q;
    logic [CTRL_DLY-1:0] rst_pipe;
    logic [CTRL_DLY-1:0] slp_pipe;

    // Mode register: clear wins over a write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sync_q <= 1'b0;
            src_q  <= 1'b0;
        end else if (mode_wr_i) begin
            sync_q <= mode_sync_i;
            src_q  <= mode_src_i;
        end
    end

    // Select source: bits when the source mode is set, else pins.
    always_comb begin
        fsel_mux = src_q ? bit_fsel_i : pin_fsel_i;
        psel_mux = src_q ? bit_psel_i : pin_psel_i;
    end

    // First pipeline stage: sample the chosen selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsel_q <= '0;
            psel_q <= '0;
        end else begin
            fsel_q <= fsel_mux;
            psel_q <= psel_mux;
        end
    end

    // Delay lines that align reset and sleep with the looked-up words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pipe <= '0;
            slp_pipe <= '0;
        end else begin
            rst_pipe <= {rst_pipe[CTRL_DLY-2:0], acc_reset_i};
            slp_pipe <= {slp_pipe[CTRL_DLY-2:0], sleep_i};
        end
    end

    assign mode_sync_o = sync_q;
    assign mode_src_o  = src_q;
    assign fsel_o      = fsel_q;
    assign psel_o      = psel_q;
    assign acc_clr_o   = rst_pipe[CTRL_DLY-1];
    assign acc_hold_o  = slp_pipe[CTRL_DLY-1];
endmodule

// File: rtl/dds_regfile.sv
// Module: dds_regfile
// Stores the tuning words and phase offsets, and looks up the selected pair
// into registers (one pipeline stage).
// Assumes: writes to indices beyond the word count are dropped.
module dds_regfile #(
    parameter int ACC_W   = 32,
    parameter int OUT_W   = 12,
    parameter int N_FREQ  = 2,
    parameter int N_PHASE = 4,
    parameter int FSEL_W  = 1,
    parameter int PSEL_W  = 2,
    parameter int ADDR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_kind_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [ACC_W-1:0]  wr_data_i,
    input  logic [FSEL_W-1:0] fsel_i,
    input  logic [PSEL_W-1:0] psel_i,
    output logic [ACC_W-1:0]  freq_o,
    output logic [OUT_W-1:0]  poff_o
);
    import dds_pkg::*;

    logic [N_FREQ-1:0][ACC_W-1:0]  freg;
    logic [N_PHASE-1:0][OUT_W-1:0] preg;

    // Write port: one word per cycle, kind picks the bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freg <= '0;
            preg <= '0;
        end else if (wr_en_i) begin
            if (wr_kind_i == WR_FREQ) begin
                for (int i = 0; i < N_FREQ; i++) begin
                    if (wr_addr_i == ADDR_W'(i)) freg[i] <= wr_data_i;
                end
            end else begin
                for (int i = 0; i < N_PHASE; i++) begin
                    if (wr_addr_i == ADDR_W'(i)) preg[i] <= wr_data_i[OUT_W-1:0];
                end
            end
        end
    end

    // Registered lookup of the selected tuning word and offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_o <= '0;
            poff_o <= '0;
        end else begin
            freq_o <= freg[fsel_i];
            poff_o <= preg[psel_i];
        end
    end

    AST_REG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(freg) && $stable(preg))); // R7
endmodule

// File: rtl/dds_resync.sv
// Module: dds_resync
// Optional delay of STAGES registers on a word bus; when enabled the output
// comes from the end of the chain, otherwise the input passes straight on.
// Assumes: STAGES >= 1; the chain runs all the time so enabling is glitch-tolerant.
module dds_resync #(
    parameter int W      = 44,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the word through the resync chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d_i;
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
        end
    end

    assign q_o = en_i ? chain[STAGES-1] : d_i;
endmodule

// File: rtl/dds_accum.sv
// Module: dds_accum
// Phase accumulator, offset addition on the top bits, and output delay line.
// Assumes: clear has priority over hold; OUT_DLY >= 1; ACC_W >= OUT_W.
module dds_accum #(
    parameter int ACC_W   = 32,
    parameter int OUT_W   = 12,
    parameter int OUT_DLY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             hold_i,
    input  logic [ACC_W-1:0] freq_i,
    input  logic [OUT_W-1:0] poff_i,
    output logic [OUT_W-1:0] phase_o
);
    logic [ACC_W-1:0]              acc;
    logic [OUT_W-1:0]              poff_d;
    logic [OUT_W-1:0]              sum_q;
    logic [OUT_DLY-1:0][OUT_W-1:0] dly;

    // Accumulate, hold during sleep, or zero on accumulator reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            acc <= '0;
        end else if (!hold_i) begin
            acc <= acc + freq_i;
        end
    end

    // Offset alignment register and modulo sum on the top bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poff_d <= '0;
            sum_q  <= '0;
        end else begin
            poff_d <= poff_i;
            sum_q  <= acc[ACC_W-1 -: OUT_W] + poff_d;
        end
    end

    // Output delay line that pads the path to its fixed latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly <= '0;
        end else begin
            dly[0] <= sum_q;
            for (int k = 1; k < OUT_DLY; k++) dly[k] <= dly[k-1];
        end
    end

    assign phase_o = dly[OUT_DLY-1];

    AST_ACC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc == '0)); // R7
    AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !clr_i) |=> $stable(acc)); // R11
    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !clr_i) |=> (acc == $past(acc) + $past(freq_i))); // R2
endmodule

// File: rtl/dds_phase_core.sv
// Module: dds_phase_core (top)
// DDS phase generator: control/select stage, word store with lookup,
// optional resync stages, accumulator and output pipeline.
// Assumes: latency without resync is six edges from sampling to output.
module dds_phase_core #(
    parameter int ACC_W       = dds_pkg::ACC_W_DEF,
    parameter int OUT_W       = dds_pkg::OUT_W_DEF,
    parameter int N_FREQ      = dds_pkg::N_FREQ_DEF,
    parameter int N_PHASE     = dds_pkg::N_PHASE_DEF,
    parameter int SYNC_STAGES = dds_pkg::SYNC_STAGES_DEF,
    localparam int FSEL_W     = (N_FREQ  > 1) ? $clog2(N_FREQ)  : 1,
    localparam int PSEL_W     = (N_PHASE > 1) ? $clog2(N_PHASE) : 1,
    localparam int ADDR_W     = (FSEL_W > PSEL_W) ? FSEL_W : PSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_kind_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [ACC_W-1:0]  wr_data_i,
    input  logic              mode_wr_i,
    input  logic              mode_sync_i,
    input  logic              mode_src_i,
    input  logic              clr_i,
    input  logic              acc_reset_i,
    input  logic              sleep_i,
    input  logic [FSEL_W-1:0] pin_fsel_i,
    input  logic [PSEL_W-1:0] pin_psel_i,
    input  logic [FSEL_W-1:0] bit_fsel_i,
    input  logic [PSEL_W-1:0] bit_psel_i,
    output logic [OUT_W-1:0]  phase_o
);
    localparam int CTRL_DLY = 2;
    localparam int OUT_DLY  = 2;
    localparam int WORD_W   = ACC_W + OUT_W;

    logic              mode_sync;
    logic              mode_src;
    logic [FSEL_W-1:0] fsel_s;
    logic [PSEL_W-1:0] psel_s;
    logic              acc_clr;
    logic              acc_hold;
    logic [ACC_W-1:0]  freq_lk;
    logic [OUT_W-1:0]  poff_lk;
    logic [WORD_W-1:0] word_rs;

    dds_ctrl #(
        .FSEL_W   (FSEL_W),
        .PSEL_W   (PSEL_W),
        .CTRL_DLY (CTRL_DLY)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .mode_wr_i   (mode_wr_i),
        .mode_sync_i (mode_sync_i),
        .mode_src_i  (mode_src_i),
        .pin_fsel_i  (pin_fsel_i),
        .pin_psel_i  (pin_psel_i),
        .bit_fsel_i  (bit_fsel_i),
        .bit_psel_i  (bit_psel_i),
        .acc_reset_i (acc_reset_i),
        .sleep_i     (sleep_i),
        .mode_sync_o (mode_sync),
        .mode_src_o  (mode_src),
        .fsel_o      (fsel_s),
        .psel_o      (psel_s),
        .acc_clr_o   (acc_clr),
        .acc_hold_o  (acc_hold)
    );

    dds_regfile #(
        .ACC_W   (ACC_W),
        .OUT_W   (OUT_W),
        .N_FREQ  (N_FREQ),
        .N_PHASE (N_PHASE),
        .FSEL_W  (FSEL_W),
        .PSEL_W  (PSEL_W),
        .ADDR_W  (ADDR_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_kind_i (wr_kind_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .fsel_i    (fsel_s),
        .psel_i    (psel_s),
        .freq_o    (freq_lk),
        .poff_o    (poff_lk)
    );

    dds_resync #(
        .W      (WORD_W),
        .STAGES (SYNC_STAGES)
    ) resync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (mode_sync),
        .d_i   ({poff_lk, freq_lk}),
        .q_o   (word_rs)
    );

    dds_accum #(
        .ACC_W   (ACC_W),
        .OUT_W   (OUT_W),
        .OUT_DLY (OUT_DLY)
    ) accum_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (acc_clr),
        .hold_i  (acc_hold),
        .freq_i  (word_rs[ACC_W-1:0]),
        .poff_i  (word_rs[WORD_W-1:ACC_W]),
        .phase_o (phase_o)
    );

    AST_CLR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!mode_sync && !mode_src)); // R9
    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_i && !clr_i) |=> (mode_sync == $past(mode_sync_i) && mode_src == $past(mode_src_i))); // R12
endmodule

// File: tb/dds_phase_core_tb_top.sv
`timescale 1ns/1ps
module dds_phase_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en_i, wr_kind_i;
    logic [1:0]  wr_addr_i;
    logic [31:0] wr_data_i;
    logic        mode_wr_i, mode_sync_i, mode_src_i, clr_i, acc_reset_i, sleep_i;
    logic        pin_fsel_i, bit_fsel_i;
    logic [1:0]  pin_psel_i, bit_psel_i;
    logic [11:0] phase_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dds_phase_core dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_kind_i(wr_kind_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .mode_wr_i(mode_wr_i),
        .mode_sync_i(mode_sync_i), .mode_src_i(mode_src_i), .clr_i(clr_i),
        .acc_reset_i(acc_reset_i), .sleep_i(sleep_i), .pin_fsel_i(pin_fsel_i),
        .pin_psel_i(pin_psel_i), .bit_fsel_i(bit_fsel_i), .bit_psel_i(bit_psel_i),
        .phase_o(phase_o)
    );

    typedef struct packed {
        logic [31:0] f;
        logic [11:0] p;
        logic        fs;
        logic [1:0]  ps;
        logic        sy;
        logic        sr;
    } vec_t;

    // Each vector: tuning word, offset, targets, resync mode, source mode.
    localparam vec_t VECS [6] = '{
        '{32'h0010_0000, 12'h000, 1'b0, 2'd0, 1'b0, 1'b0},
        '{32'h0123_4567, 12'h7FF, 1'b1, 2'd2, 1'b0, 1'b0},
        '{32'hFFF0_0000, 12'h005, 1'b0, 2'd3, 1'b1, 1'b0},
        '{32'h8000_0000, 12'hFFF, 1'b1, 2'd1, 1'b0, 1'b1},
        '{32'h0000_0001, 12'h123, 1'b0, 2'd2, 1'b1, 1'b1},
        '{32'hDEAD_BEEF, 12'hABC, 1'b1, 2'd0, 1'b1, 1'b1}
    };

    task automatic tick(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: phase_o=%03h expected %03h", req, act, exp);
        end
    endtask

    task automatic wr(input logic kind, input logic [1:0] addr, input logic [31:0] data);
        wr_en_i = 1'b1; wr_kind_i = kind; wr_addr_i = addr; wr_data_i = data;
        tick(1);
        wr_en_i = 1'b0;
    endtask

    task automatic mode_write(input logic s, input logic r);
        mode_wr_i = 1'b1; mode_sync_i = s; mode_src_i = r;
        tick(1);
        mode_wr_i = 1'b0;
    endtask

    function automatic logic [11:0] model_phase(input logic [31:0] f, input logic [11:0] p, input int n);
        logic [31:0] a;
        a = f * 32'(n);
        return a[31:20] + p;
    endfunction

    initial begin
        logic [11:0] a, b;
        rst_n = 1'b0; wr_en_i = 1'b0; wr_kind_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
        mode_wr_i = 1'b0; mode_sync_i = 1'b0; mode_src_i = 1'b0; clr_i = 1'b0;
        acc_reset_i = 1'b0; sleep_i = 1'b0; pin_fsel_i = 1'b0; bit_fsel_i = 1'b0;
        pin_psel_i = '0; bit_psel_i = '0;
        tick(3);
        check("R1 reset", phase_o, 12'h000);
        rst_n = 1'b1;
        tick(4);
        check("R1 after reset", phase_o, 12'h000);

        // Vector table: reset hold, then release and accumulate (R2 R3 R7 R8 R10 R12)
        for (int i = 0; i < 6; i++) begin
            acc_reset_i = 1'b1;
            mode_write(VECS[i].sy, VECS[i].sr);
            wr(1'b0, {1'b0, VECS[i].fs}, VECS[i].f);
            wr(1'b0, {1'b0, ~VECS[i].fs}, 32'h0555_0000);
            wr(1'b1, VECS[i].ps, {20'h0, VECS[i].p});
            wr(1'b1, VECS[i].ps ^ 2'b01, 32'h0000_09E3);
            if (VECS[i].sr) begin
                bit_fsel_i = VECS[i].fs;  bit_psel_i = VECS[i].ps;
                pin_fsel_i = ~VECS[i].fs; pin_psel_i = VECS[i].ps ^ 2'b01;
            end else begin
                pin_fsel_i = VECS[i].fs;  pin_psel_i = VECS[i].ps;
                bit_fsel_i = ~VECS[i].fs; bit_psel_i = VECS[i].ps ^ 2'b01;
            end
            tick(12);
            check("R7 held reset shows offset", phase_o, VECS[i].p);
            acc_reset_i = 1'b0;
            tick(5);
            check("R8 before release reaches output", phase_o, VECS[i].p);
            for (int j = 0; j < 4; j++) begin
                tick(1);
                check("R2 R8 R10 accumulate", phase_o, model_phase(VECS[i].f, VECS[i].p, j + 1));
            end
        end

        // Directed: latency of selects and writes
        acc_reset_i = 1'b1;
        mode_write(1'b0, 1'b0);
        wr(1'b0, 2'd0, 32'h0);
        wr(1'b0, 2'd1, 32'h0);
        wr(1'b1, 2'd0, 32'h111);
        wr(1'b1, 2'd1, 32'h222);
        wr(1'b1, 2'd2, 32'h333);
        wr(1'b1, 2'd3, 32'h444);
        pin_psel_i = 2'd0; pin_fsel_i = 1'b0;
        tick(12);
        acc_reset_i = 1'b0;
        tick(10);
        check("R3 offset 0 selected", phase_o, 12'h111);
        pin_psel_i = 2'd1;
        tick(5);
        check("R4 select before latency", phase_o, 12'h111);
        tick(1);
        check("R4 select at six edges", phase_o, 12'h222);
        mode_write(1'b1, 1'b0);
        tick(10);
        check("R12 mode load keeps selection", phase_o, 12'h222);
        pin_psel_i = 2'd2;
        tick(7);
        check("R5 resync select before latency", phase_o, 12'h222);
        tick(1);
        check("R5 R12 resync select at eight edges", phase_o, 12'h333);
        wr(1'b1, 2'd2, 32'h5A5);
        tick(6);
        check("R6 resync write before latency", phase_o, 12'h333);
        tick(1);
        check("R6 resync write at eight edges", phase_o, 12'h5A5);
        mode_write(1'b0, 1'b0);
        tick(10);
        wr(1'b1, 2'd2, 32'h6B6);
        tick(4);
        check("R6 write before latency", phase_o, 12'h5A5);
        tick(1);
        check("R6 write at six edges", phase_o, 12'h6B6);

        // Frequency select latency
        wr(1'b0, 2'd1, 32'h0010_0000);
        tick(8);
        check("R3 zero tuning word holds phase", phase_o, 12'h6B6);
        pin_fsel_i = 1'b1;
        tick(5);
        check("R4 freq select before latency", phase_o, 12'h6B6);
        tick(1);
        check("R4 freq select at six edges", phase_o, 12'h6B7);
        tick(1);
        check("R2 next step", phase_o, 12'h6B8);

        // Sleep
        sleep_i = 1'b1;
        tick(4);
        a = phase_o;
        tick(1);
        b = phase_o;
        check("R11 still stepping after N+4", b, a + 12'd1);
        tick(1);
        check("R11 frozen after N+5", phase_o, b);
        tick(3);
        check("R11 stays frozen", phase_o, b);
        sleep_i = 1'b0;
        tick(5);
        check("R11 frozen until release latency", phase_o, b);
        tick(1);
        check("R11 resumes stepping", phase_o, b + 12'd1);

        // Accumulator reset keeps stored words
        acc_reset_i = 1'b1;
        tick(8);
        check("R7 reset zeroes accumulator keeps offset", phase_o, 12'h6B6);
        acc_reset_i = 1'b0;
        tick(5);
        check("R8 release before latency", phase_o, 12'h6B6);
        tick(1);
        check("R7 R8 tuning word kept", phase_o, 12'h6B7);
        tick(1);
        check("R8 second step", phase_o, 12'h6B8);

        // Source select and clear
        acc_reset_i = 1'b1;
        bit_psel_i = 2'd3; pin_psel_i = 2'd1;
        mode_write(1'b1, 1'b1);
        tick(12);
        check("R10 bits select offset 3", phase_o, 12'h444);
        clr_i = 1'b1; mode_wr_i = 1'b1; mode_sync_i = 1'b1; mode_src_i = 1'b1;
        tick(1);
        clr_i = 1'b0; mode_wr_i = 1'b0;
        tick(7);
        check("R9 clear returns to pins", phase_o, 12'h222);
        pin_psel_i = 2'd0;
        tick(5);
        check("R9 resync off after clear, before latency", phase_o, 12'h222);
        tick(1);
        check("R9 six-edge latency after clear", phase_o, 12'h111);
        bit_psel_i = 2'd2;
        tick(10);
        check("R10 bits ignored with pin source", phase_o, 12'h111);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule